// File: doc/BRIEF.md
# Leveled Interrupt Acceptance Arbiter with DMA Precedence

This block decides, every clock, whether a pending DMA channel invocation is started or whether the CPU takes an interrupt. The interrupt sources each carry a 3-bit priority level. A DMA invocation always beats an interrupt. While a DMA transfer is running, the block starts nothing and accepts nothing.

An interrupt is taken only when the processor's global interrupt enable is set and the winning source's level is strictly above the processor's current level. On acceptance the block emits a one-cycle pulse together with the winning source index and its vector address. The vector address is the trap table base plus a slot offset per source, with four bytes per slot.

The DMA engine consumes the one-hot start grant and raises its busy flag in the cycle after it sees the grant. The CPU consumes the accept pulse, index and vector, and raises its level before the arbiter's one-cycle hold-off ends.

Top module: `irq_dma_arbiter`

## Requirements
- R1: While reset is high, and after it until the first decision, the grant is all zero, the accept pulse is low, and the index and vector outputs are zero.
- R2: Among sources whose request bit is 1, the one with the numerically highest level is the candidate for acceptance.
- R3: When several requesting sources share the highest level, the source with the lowest index is the candidate.
- R4: An interrupt is accepted only when the enable input is 1 and the candidate's level is strictly greater than the processor level input. A level of 0 is therefore never accepted.
- R5: When any DMA request bit is 1 and the arbiter is not locked, a grant is issued in that decision and no interrupt is accepted.
- R6: In a cycle where the DMA busy input is 1, the next outputs carry no grant and no accept pulse, whatever the priorities are.
- R7: The grant is one-hot, selects the lowest-index requesting DMA channel, and lasts one cycle. The decision made while a grant is visible issues nothing.
- R8: The accept pulse lasts one cycle, and the decision made while it is high issues nothing. Index and vector change only together with a pulse and hold their value otherwise.
- R9: The vector equals the trap base plus (16 + index) × 4, truncated to 24 bits. With base 0xC00000, source 10 (the DMA-completion source) gives 0xC00068.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 16 | Pending interrupt request per source |
| irq_lvl_i | input | 48 | Level per source, 3 bits each; source i uses bits [3i+2:3i] |
| dma_req_i | input | 4 | Pending DMA invocation per channel |
| dma_busy_i | input | 1 | DMA transfer in flight |
| cpu_ie_i | input | 1 | Processor global interrupt enable |
| cpu_lvl_i | input | 3 | Processor current interrupt level |
| trap_base_i | input | 24 | Trap table base address |
| dma_gnt_o | output | 4 | One-hot DMA start grant pulse |
| irq_take_o | output | 1 | Interrupt accept pulse |
| irq_idx_o | output | 4 | Index of the accepted source |
| irq_vec_o | output | 24 | Vector address of the accepted source |

## Verification
A wrong lock state shows one cycle later at the ports in one of two ways. It can produce a second back-to-back grant or accept pulse. It can also produce a pulse issued during a busy cycle. A stale or wrong level-selection result shows as a wrong index or vector on the very next accept pulse. A dropped DMA precedence shows as an accept pulse in place of a grant in the same decision. The scoreboard compares every output field in every cycle, so each of these errors is caught in the cycle it first appears.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;

    localparam int unsigned LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        DEC_NONE = 2'd0,
        DEC_DMA  = 2'd1,
        DEC_IRQ  = 2'd2
    } decision_e;

    // byte offset of a vector slot, four bytes per slot
    function automatic logic [31:0] slot_byte_off(input int unsigned slot0,
                                                  input int unsigned idx);
        return (32'(slot0) + 32'(idx)) << 2;
    endfunction

endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_dma_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
    output logic                     found_o,
    output logic [IDX_W-1:0]         idx_o,
    output lvl_t                     lvl_o
);
    lvl_t src_lvl [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
        assign src_lvl[g] = lvl_i[g*LVL_W +: LVL_W];
    end

    // scan upward; only a strictly higher level replaces, so ties keep the lower index
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!found_o || (src_lvl[i] > lvl_o))) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/dma_chan_pick.sv
module dma_chan_pick #(
    parameter int unsigned NUM_DMA = 4
) (
    input  logic [NUM_DMA-1:0] req_i,
    output logic               any_o,
    output logic [NUM_DMA-1:0] onehot_o
);
    always_comb begin
        onehot_o = '0;
        for (int i = NUM_DMA - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                onehot_o = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/irq_dma_decide.sv
module irq_dma_decide
    import irq_dma_pkg::*;
(
    input  logic      lock_i,
    input  logic      dma_any_i,
    input  logic      cpu_ie_i,
    input  lvl_t      cpu_lvl_i,
    input  logic      cand_found_i,
    input  lvl_t      cand_lvl_i,
    output decision_e dec_o
);
    logic irq_ok;

    // level 0 can never exceed any processor level
    assign irq_ok = cpu_ie_i && cand_found_i && (cand_lvl_i > cpu_lvl_i);

    always_comb begin
        dec_o = DEC_NONE;
        if (!lock_i) begin
            if (dma_any_i) begin
                dec_o = DEC_DMA;
            end else if (irq_ok) begin
                dec_o = DEC_IRQ;
            end
        end
    end
endmodule

// File: rtl/irq_dma_arbiter.sv
module irq_dma_arbiter
    import irq_dma_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned NUM_DMA = 4,
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned SLOT0   = 16,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       irq_req_i,
    input  logic [NUM_SRC*LVL_W-1:0] irq_lvl_i,
    input  logic [NUM_DMA-1:0]       dma_req_i,
    input  logic                     dma_busy_i,
    input  logic                     cpu_ie_i,
    input  logic [LVL_W-1:0]         cpu_lvl_i,
    input  logic [ADDR_W-1:0]        trap_base_i,
    output logic [NUM_DMA-1:0]       dma_gnt_o,
    output logic                     irq_take_o,
    output logic [IDX_W-1:0]         irq_idx_o,
    output logic [ADDR_W-1:0]        irq_vec_o
);
    logic               cand_found;
    logic [IDX_W-1:0]   cand_idx;
    lvl_t               cand_lvl;
    logic               dma_any;
    logic [NUM_DMA-1:0] dma_onehot;
    logic               lock;
    decision_e          dec;
    logic [ADDR_W-1:0]  cand_vec;

    irq_level_pick #(.NUM_SRC(NUM_SRC)) u_level_pick (
        .req_i   (irq_req_i),
        .lvl_i   (irq_lvl_i),
        .found_o (cand_found),
        .idx_o   (cand_idx),
        .lvl_o   (cand_lvl)
    );

    dma_chan_pick #(.NUM_DMA(NUM_DMA)) u_dma_pick (
        .req_i    (dma_req_i),
        .any_o    (dma_any),
        .onehot_o (dma_onehot)
    );

    // hold off while a transfer runs or while the previous decision is still visible
    assign lock = dma_busy_i | (|dma_gnt_o) | irq_take_o;

    irq_dma_decide u_decide (
        .lock_i       (lock),
        .dma_any_i    (dma_any),
        .cpu_ie_i     (cpu_ie_i),
        .cpu_lvl_i    (cpu_lvl_i),
        .cand_found_i (cand_found),
        .cand_lvl_i   (cand_lvl),
        .dec_o        (dec)
    );

    assign cand_vec = trap_base_i + ADDR_W'(slot_byte_off(SLOT0, int'(cand_idx)));

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_gnt_o  <= '0;
            irq_take_o <= 1'b0;
            irq_idx_o  <= '0;
            irq_vec_o  <= '0;
        end else begin
            dma_gnt_o  <= (dec == DEC_DMA) ? dma_onehot : '0;
            irq_take_o <= (dec == DEC_IRQ);
            if (dec == DEC_IRQ) begin
                irq_idx_o <= cand_idx;
                irq_vec_o <= cand_vec;
            end
        end
    end

    assert_candidate_requests_R2: assert property (@(posedge clk) disable iff (rst)
        cand_found |-> irq_req_i[cand_idx]);

    assert_masked_no_take_R4: assert property (@(posedge clk) disable iff (rst)
        !cpu_ie_i |=> !irq_take_o);

    assert_dma_wins_R5: assert property (@(posedge clk) disable iff (rst)
        ((|dma_req_i) && !dma_busy_i && (dma_gnt_o == '0) && !irq_take_o)
            |=> ((|dma_gnt_o) && !irq_take_o));

    assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        dma_busy_i |=> ((dma_gnt_o == '0) && !irq_take_o));

    assert_gnt_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dma_gnt_o));

    assert_gnt_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        (|dma_gnt_o) |=> ((dma_gnt_o == '0) && !irq_take_o));

    assert_take_single_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        irq_take_o |=> ((dma_gnt_o == '0) && !irq_take_o));

    assert_vec_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_take_o |-> ($stable(irq_vec_o) && $stable(irq_idx_o)));
endmodule

// File: tb/test_irq_dma_arbiter.sv
`timescale 1ns/1ps
module test_irq_dma_arbiter;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_req;
    logic [47:0] irq_lvl;
    logic [3:0]  dma_req;
    logic        dma_busy;
    logic        cpu_ie;
    logic [2:0]  cpu_lvl;
    logic [23:0] trap_base;
    logic [3:0]  dma_gnt;
    logic        irq_take;
    logic [3:0]  irq_idx;
    logic [23:0] irq_vec;

    always #2.5 clk = ~clk;

    irq_dma_arbiter i_irq_dma_arbiter (
        .clk(clk), .rst(rst), .irq_req_i(irq_req), .irq_lvl_i(irq_lvl),
        .dma_req_i(dma_req), .dma_busy_i(dma_busy), .cpu_ie_i(cpu_ie),
        .cpu_lvl_i(cpu_lvl), .trap_base_i(trap_base), .dma_gnt_o(dma_gnt),
        .irq_take_o(irq_take), .irq_idx_o(irq_idx), .irq_vec_o(irq_vec)
    );

    typedef struct {
        logic [3:0]  gnt;
        logic        take;
        logic [3:0]  idx;
        logic [23:0] vec;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [2:0]  lv [16];

    // reference state
    logic [3:0]  m_gnt  = '0;
    logic        m_take = 1'b0;
    logic [3:0]  m_idx  = '0;
    logic [23:0] m_vec  = '0;

    task automatic step(input logic r, input logic [15:0] req, input logic [3:0] dreq,
                        input logic busy, input logic ie, input logic [2:0] cur,
                        input logic [23:0] base, input string tag);
        exp_t e;
        logic lock;
        logic found;
        int   best;
        @(negedge clk);
        rst = r; irq_req = req; dma_req = dreq; dma_busy = busy;
        cpu_ie = ie; cpu_lvl = cur; trap_base = base;
        for (int i = 0; i < 16; i++) irq_lvl[i*3 +: 3] = lv[i];
        if (r) begin
            m_gnt = '0; m_take = 1'b0; m_idx = '0; m_vec = '0;
        end else begin
            lock = busy | (m_gnt != 0) | m_take;
            found = 1'b0; best = 0;
            for (int i = 0; i < 16; i++)
                if (req[i] && (!found || lv[i] > lv[best])) begin found = 1'b1; best = i; end
            m_gnt = '0; m_take = 1'b0;
            if (!lock && dreq != 0) begin
                for (int c = 3; c >= 0; c--) if (dreq[c]) m_gnt = 4'(1 << c);
            end else if (!lock && ie && found && lv[best] > cur) begin
                m_take = 1'b1;
                m_idx  = 4'(best);
                m_vec  = base + 24'((16 + best) * 4);
            end
        end
        e.gnt = m_gnt; e.take = m_take; e.idx = m_idx; e.vec = m_vec; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares outputs just after each edge against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (dma_gnt !== e.gnt || irq_take !== e.take ||
                    irq_idx !== e.idx || irq_vec !== e.vec) begin
                    errors++;
                    $display("FAIL %s: actual gnt=%b take=%b idx=%0d vec=%h expected gnt=%b take=%b idx=%0d vec=%h",
                             e.tag, dma_gnt, irq_take, irq_idx, irq_vec,
                             e.gnt, e.take, e.idx, e.vec);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [23:0] B0 = 24'hC00000;

    initial begin
        for (int i = 0; i < 16; i++) lv[i] = 3'd0;
        rst = 1'b1; irq_req = '0; irq_lvl = '0; dma_req = '0; dma_busy = 1'b0;
        cpu_ie = 1'b0; cpu_lvl = '0; trap_base = B0;

        // R1: reset state, with requests present
        lv[3] = 3'd6;
        step(1, 16'h0008, 4'h1, 0, 1, 0, B0, "R1 reset");
        step(1, 16'h0008, 4'h0, 0, 1, 0, B0, "R1 reset");
        step(0, 16'h0000, 4'h0, 0, 1, 0, B0, "R1 idle after reset");

        // R4 and R9: single source accepted; source 10 gives 0xC00068
        lv[10] = 3'd5;
        step(0, 16'h0400, 4'h0, 0, 1, 2, B0, "R9 vector 0xC00068");
        step(0, 16'h0400, 4'h0, 0, 1, 2, B0, "R8 hold-off after accept");
        step(0, 16'h0400, 4'h0, 0, 1, 5, B0, "R4 equal level rejected");
        step(0, 16'h0400, 4'h0, 0, 0, 0, B0, "R4 enable low rejected");
        lv[2] = 3'd0;
        step(0, 16'h0004, 4'h0, 0, 1, 0, B0, "R4 level zero rejected");
        step(0, 16'h0000, 4'h0, 0, 1, 0, B0, "R8 index and vector held");

        // R2: highest level among several
        lv[1] = 3'd2; lv[7] = 3'd7; lv[12] = 3'd4;
        step(0, 16'h1082, 4'h0, 0, 1, 1, B0, "R2 highest level");
        step(0, 16'h0000, 4'h0, 0, 1, 1, B0, "R8 single-cycle accept");

        // R3: tie goes to lowest index
        lv[5] = 3'd4; lv[9] = 3'd4; lv[14] = 3'd4;
        step(0, 16'h4220, 4'h0, 0, 1, 3, B0, "R3 tie lowest index");
        step(0, 16'h0000, 4'h0, 0, 1, 3, B0, "R3 idle");

        // R5 and R7: DMA beats a high-level interrupt; lowest channel granted
        step(0, 16'h0080, 4'hC, 0, 1, 0, B0, "R5 DMA precedence");
        step(0, 16'h0080, 4'hC, 0, 1, 0, B0, "R7 hold-off after grant");
        // R6: busy blocks everything
        step(0, 16'h0080, 4'hC, 1, 1, 0, B0, "R6 busy blocks");
        step(0, 16'h0080, 4'hC, 1, 1, 0, B0, "R6 busy blocks");
        step(0, 16'h0080, 4'h8, 0, 1, 0, B0, "R7 lowest channel after busy");
        step(0, 16'h0080, 4'h0, 1, 1, 0, B0, "R6 busy blocks interrupt");
        step(0, 16'h0080, 4'h0, 0, 1, 0, B0, "R4 accepted after transfer");

        // R9: other base and index, wrapping in 24 bits
        lv[0] = 3'd3;
        step(0, 16'h0000, 4'h0, 0, 1, 0, 24'hFFFFF0, "R9 idle");
        step(0, 16'h0001, 4'h0, 0, 1, 0, 24'hFFFFF0, "R9 vector wrap");
        step(0, 16'h0000, 4'h2, 0, 1, 0, B0, "R7 channel one");
        step(0, 16'h0000, 4'h0, 0, 1, 0, B0, "R8 held after grant");
        step(0, 16'h0000, 4'h0, 0, 1, 0, B0, "R1 quiet");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule